// File: doc/BRIEF.md
# Block-Number Sync Interval Regenerator

This stage sits in a block-oriented sample stream. Every block carries a start marker, an end marker, a per-sample valid, a data word and a block sequence number (BSN). The stage passes these fields through one register stage unchanged. It drops the incoming sync marker and builds a new sync pattern whose period is given in samples. Because the period is in samples, it may cover a fractional number of blocks.

Control software programs a start BSN and a period, then raises the enable level together with a one-cycle event pulse. Forwarding begins on the first arriving block whose BSN has reached the start BSN. The sync pattern is then derived from the BSN values themselves, so idle gaps and lost blocks do not shift it. Dropping the enable level stops the output cleanly at the next block boundary. A fresh event while the stage is running re-anchors the pattern at a new start BSN. Three status outputs report the last input BSN, the BSN of the last input sync and the BSN of the last regenerated sync.

Top module: `bsn_sync_regen`

## Requirements
- R1: While `out_enable` is high, `out_bsn`, `out_data`, `out_valid`, `out_sop` and `out_eop` equal the corresponding inputs of the previous clock cycle.
- R2: When `ctl_en` and `ctl_evt` are both high, the stage is armed. Forwarding begins at the first valid `in_sop` whose `in_bsn` is greater than or equal to `ctl_start_bsn`. Earlier blocks are not forwarded.
- R3: If `ctl_start_bsn` is not greater than `mon_cur_bsn` when the event arrives, the stage is not armed, and the output stays disabled for all later blocks until the next event.
- R4: When `ctl_en` goes low during a block, that block is still forwarded in full, and `out_enable` falls in the cycle after `out_eop`. When `ctl_en` goes low during an idle gap, no further block is forwarded.
- R5: `out_start` is high only on the first output block after an accepted event. That block also carries `out_sync` together with `out_sop`.
- R6: With block size B, period P (in samples) and block offset k = BSN minus the start BSN, block k carries `out_sync` exactly when some integer m satisfies k·B ≤ m·P ≤ k·B + B − 1. The period may be a fractional number of blocks, for example P = 45 with B = 10.
- R7: An accepted event while the output is running is a re-enable. Forwarding continues with the old pattern until the block that reaches the new start BSN. That block gets `out_start` and `out_sync`, and from it onward the new start BSN and the new period define the pattern.
- R8: Idle gaps between blocks do not affect the output. When blocks are missing, a forwarded block carries `out_sync` if any period boundary lies between the first sample after the previously forwarded block and the last sample of this block.
- R9: `mon_cur_bsn` holds the BSN of the last valid input block start. `mon_in_sync_bsn` holds the BSN of the last input block start that had `in_sync` set. `mon_out_sync_bsn` equals `out_bsn` whenever `out_sync` is high, and keeps that value afterwards.
- R10: A synchronous active-high reset clears the enable state, any pending start and all status values. While `out_enable` is low, `out_valid`, `out_sop`, `out_eop`, `out_sync` and `out_start` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_en | input | 1 | Enable level |
| ctl_evt | input | 1 | One-cycle control event pulse |
| ctl_start_bsn | input | BSN_W | BSN at which output should begin |
| ctl_period | input | PER_W | Output sync period in samples |
| in_sop | input | 1 | Input block start marker |
| in_eop | input | 1 | Input block end marker |
| in_valid | input | 1 | Input sample valid |
| in_sync | input | 1 | Input sync marker (consumed, not forwarded) |
| in_bsn | input | BSN_W | Input block sequence number |
| in_data | input | DATA_W | Input sample |
| out_sop | output | 1 | Output block start marker |
| out_eop | output | 1 | Output block end marker |
| out_valid | output | 1 | Output sample valid |
| out_sync | output | 1 | Regenerated sync marker |
| out_bsn | output | BSN_W | Output block sequence number |
| out_data | output | DATA_W | Output sample |
| out_start | output | 1 | First output block after an enable |
| out_enable | output | 1 | Output currently forwarding |
| mon_cur_bsn | output | BSN_W | Last input block BSN |
| mon_in_sync_bsn | output | BSN_W | BSN of last input sync block |
| mon_out_sync_bsn | output | BSN_W | BSN of last output sync block |

## Verification
The assertions assume well-formed input framing. Each block opens with a valid start marker and closes with a valid end marker, blocks never overlap, and the BSN rises from one arriving block to the next without wrapping while output is active. The period is assumed non-zero. The stimulus builds every block from a single task that keeps this framing, inserts idle gaps of fixed length between blocks, and models loss by skipping BSN values rather than by sending broken blocks. Control events are issued only in idle gaps, while the enable level may also drop in the middle of a block.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

    typedef enum logic [1:0] {
        MODE_OFF       = 2'd0,
        MODE_ARMED     = 2'd1,
        MODE_RUN       = 2'd2,
        MODE_RUN_ARMED = 2'd3
    } mode_e;

    function automatic logic mode_running(mode_e m);
        return (m == MODE_RUN) || (m == MODE_RUN_ARMED);
    endfunction

    function automatic logic mode_armed(mode_e m);
        return (m == MODE_ARMED) || (m == MODE_RUN_ARMED);
    endfunction

    function automatic mode_e mode_pack(logic run, logic arm);
        mode_e m;
        case ({run, arm})
            2'b00:   m = MODE_OFF;
            2'b01:   m = MODE_ARMED;
            2'b10:   m = MODE_RUN;
            default: m = MODE_RUN_ARMED;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/bsr_ctrl.sv
module bsr_ctrl
    import bsr_pkg::*;
#(
    parameter int BSN_W = 31,
    parameter int PER_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_lvl,
    input  logic             en_evt,
    input  logic [BSN_W-1:0] start_bsn,
    input  logic [PER_W-1:0] period,
    input  logic [BSN_W-1:0] cur_bsn,
    input  logic             in_sop,
    input  logic             in_eop,
    input  logic             in_valid,
    input  logic [BSN_W-1:0] in_bsn,
    output logic             fwd,
    output logic             start_hit,
    output logic [BSN_W-1:0] eff_ref,
    output logic [PER_W-1:0] eff_per
);

    typedef struct packed {
        mode_e            mode;
        logic             blk_open;
        logic [BSN_W-1:0] arm_bsn;
        logic [PER_W-1:0] arm_per;
        logic [BSN_W-1:0] ref_bsn;
        logic [PER_W-1:0] ref_per;
    } ctl_t;

    ctl_t s_d, s_q;

    logic sop_v, eop_v, armed, running, evt_ok, run_nx, arm_nx;

    always_comb begin
        s_d       = s_q;
        sop_v     = in_sop & in_valid;
        eop_v     = in_eop & in_valid;
        armed     = mode_armed(s_q.mode);
        running   = mode_running(s_q.mode);
        evt_ok    = en_lvl & en_evt & (start_bsn > cur_bsn);
        start_hit = armed & en_lvl & sop_v & (in_bsn >= s_q.arm_bsn);
        fwd       = start_hit | (running & (en_lvl | s_q.blk_open));

        if (sop_v & ~eop_v) begin
            s_d.blk_open = 1'b1;
        end else if (eop_v) begin
            s_d.blk_open = 1'b0;
        end

        run_nx = start_hit | (running & (en_lvl | (s_q.blk_open & ~eop_v)));
        if (en_lvl & en_evt) begin
            arm_nx = evt_ok;
        end else begin
            arm_nx = armed & en_lvl & ~start_hit;
        end

        if (evt_ok) begin
            s_d.arm_bsn = start_bsn;
            s_d.arm_per = period;
        end
        if (start_hit) begin
            s_d.ref_bsn = s_q.arm_bsn;
            s_d.ref_per = s_q.arm_per;
        end
        s_d.mode = mode_pack(run_nx, arm_nx);

        eff_ref = start_hit ? s_q.arm_bsn : s_q.ref_bsn;
        eff_per = start_hit ? s_q.arm_per : s_q.ref_per;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // R4: a block that is open and not ending keeps the stage running
    p_no_midblock_stop_r4 : assert property (@(posedge clk) disable iff (rst)
        (running && s_q.blk_open && !eop_v) |=> mode_running(s_q.mode));

    // R2: arming only follows an event
    p_arm_by_event_r2 : assert property (@(posedge clk) disable iff (rst)
        (!armed && !(en_lvl && en_evt)) |=> !mode_armed(s_q.mode));

    // R7: the new reference never lies beyond the block that started it
    p_ref_not_ahead_r7 : assert property (@(posedge clk) disable iff (rst)
        start_hit |=> (s_q.ref_bsn <= $past(in_bsn)));

endmodule

// File: rtl/bsr_sync_gen.sv
module bsr_sync_gen #(
    parameter int BSN_W = 31,
    parameter int PER_W = 16,
    parameter int BLK   = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             blk_fire,
    input  logic             restart,
    input  logic [BSN_W-1:0] bsn,
    input  logic [BSN_W-1:0] ref_bsn,
    input  logic [PER_W-1:0] per,
    output logic             sync_now
);

    localparam int OFS_W = $clog2(BLK + 1);
    localparam int IDX_W = BSN_W + OFS_W + 1;

    typedef struct packed {
        logic [IDX_W-1:0] quot;
    } sg_t;

    sg_t s_d, s_q;

    logic [BSN_W-1:0] rel_b;
    logic [IDX_W-1:0] last_idx, per_ext, quot;

    always_comb begin
        s_d      = s_q;
        rel_b    = bsn - ref_bsn;
        // index of the last sample of this block, counted from the start BSN
        last_idx = (IDX_W'(rel_b) + IDX_W'(1)) * IDX_W'(BLK) - IDX_W'(1);
        per_ext  = (per == '0) ? IDX_W'(1) : IDX_W'(per);
        quot     = last_idx / per_ext;
        // a boundary was crossed since the last forwarded block if the
        // number of whole periods up to the block end has changed
        sync_now = blk_fire & (restart | (quot != s_q.quot));
        if (blk_fire) begin
            s_d.quot = quot;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // R8: period count only moves forward between restarts
    p_count_forward_r8 : assert property (@(posedge clk) disable iff (rst)
        (blk_fire && !restart) |-> (quot >= s_q.quot));

endmodule

// File: rtl/bsr_status.sv
module bsr_status #(
    parameter int BSN_W = 31
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sop_v,
    input  logic             in_sync,
    input  logic             out_sync_fire,
    input  logic [BSN_W-1:0] in_bsn,
    output logic [BSN_W-1:0] cur_bsn,
    output logic [BSN_W-1:0] in_sync_bsn,
    output logic [BSN_W-1:0] out_sync_bsn
);

    typedef struct packed {
        logic [BSN_W-1:0] cur;
        logic [BSN_W-1:0] isync;
        logic [BSN_W-1:0] osync;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (sop_v) begin
            s_d.cur = in_bsn;
            if (in_sync) begin
                s_d.isync = in_bsn;
            end
        end
        if (out_sync_fire) begin
            s_d.osync = in_bsn;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cur_bsn      = s_q.cur;
    assign in_sync_bsn  = s_q.isync;
    assign out_sync_bsn = s_q.osync;

endmodule

// File: rtl/bsn_sync_regen.sv
module bsn_sync_regen #(
    parameter int BSN_W    = 31,
    parameter int DATA_W   = 16,
    parameter int BLK_SIZE = 10,
    parameter int PER_W    = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_en,
    input  logic              ctl_evt,
    input  logic [BSN_W-1:0]  ctl_start_bsn,
    input  logic [PER_W-1:0]  ctl_period,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic              in_valid,
    input  logic              in_sync,
    input  logic [BSN_W-1:0]  in_bsn,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_sop,
    output logic              out_eop,
    output logic              out_valid,
    output logic              out_sync,
    output logic [BSN_W-1:0]  out_bsn,
    output logic [DATA_W-1:0] out_data,
    output logic              out_start,
    output logic              out_enable,
    output logic [BSN_W-1:0]  mon_cur_bsn,
    output logic [BSN_W-1:0]  mon_in_sync_bsn,
    output logic [BSN_W-1:0]  mon_out_sync_bsn
);

    typedef struct packed {
        logic              sop;
        logic              eop;
        logic              valid;
        logic              sync;
        logic              start;
        logic              en;
        logic [BSN_W-1:0]  bsn;
        logic [DATA_W-1:0] data;
    } out_t;

    out_t o_d, o_q;

    logic             fwd, start_hit, sync_now, blk_fire, sop_v;
    logic [BSN_W-1:0] eff_ref;
    logic [PER_W-1:0] eff_per;

    assign sop_v    = in_sop & in_valid;
    assign blk_fire = fwd & sop_v;

    bsr_ctrl #(.BSN_W(BSN_W), .PER_W(PER_W)) ctrl_i (
        .clk       (clk),
        .rst       (rst),
        .en_lvl    (ctl_en),
        .en_evt    (ctl_evt),
        .start_bsn (ctl_start_bsn),
        .period    (ctl_period),
        .cur_bsn   (mon_cur_bsn),
        .in_sop    (in_sop),
        .in_eop    (in_eop),
        .in_valid  (in_valid),
        .in_bsn    (in_bsn),
        .fwd       (fwd),
        .start_hit (start_hit),
        .eff_ref   (eff_ref),
        .eff_per   (eff_per)
    );

    bsr_sync_gen #(.BSN_W(BSN_W), .PER_W(PER_W), .BLK(BLK_SIZE)) sync_i (
        .clk      (clk),
        .rst      (rst),
        .blk_fire (blk_fire),
        .restart  (start_hit),
        .bsn      (in_bsn),
        .ref_bsn  (eff_ref),
        .per      (eff_per),
        .sync_now (sync_now)
    );

    bsr_status #(.BSN_W(BSN_W)) stat_i (
        .clk           (clk),
        .rst           (rst),
        .sop_v         (sop_v),
        .in_sync       (in_sync),
        .out_sync_fire (sync_now),
        .in_bsn        (in_bsn),
        .cur_bsn       (mon_cur_bsn),
        .in_sync_bsn   (mon_in_sync_bsn),
        .out_sync_bsn  (mon_out_sync_bsn)
    );

    always_comb begin
        o_d       = o_q;
        o_d.en    = fwd;
        o_d.valid = fwd & in_valid;
        o_d.sop   = fwd & in_valid & in_sop;
        o_d.eop   = fwd & in_valid & in_eop;
        o_d.sync  = sync_now;
        o_d.start = start_hit;
        o_d.bsn   = in_bsn;
        o_d.data  = in_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign out_sop    = o_q.sop;
    assign out_eop    = o_q.eop;
    assign out_valid  = o_q.valid;
    assign out_sync   = o_q.sync;
    assign out_start  = o_q.start;
    assign out_enable = o_q.en;
    assign out_bsn    = o_q.bsn;
    assign out_data   = o_q.data;

    p_start_carries_sync_r5 : assert property (@(posedge clk) disable iff (rst)
        out_start |-> (out_sync && out_sop));

    p_quiet_when_off_r10 : assert property (@(posedge clk) disable iff (rst)
        !out_enable |-> !(out_valid || out_sop || out_eop || out_sync || out_start));

    p_sync_on_block_start_r6 : assert property (@(posedge clk) disable iff (rst)
        out_sync |-> (out_sop && out_valid && out_enable));

    p_out_sync_status_r9 : assert property (@(posedge clk) disable iff (rst)
        out_sync |-> (mon_out_sync_bsn == out_bsn));

    p_enable_drop_after_eop_r4 : assert property (@(posedge clk) disable iff (rst)
        $fell(out_enable) |-> ($past(out_eop) || !$past(out_valid)));

endmodule

// File: tb/bsn_sync_regen_tb_top.sv
`timescale 1ns/1ps
module bsn_sync_regen_tb_top;

    localparam int BSN_W = 31;
    localparam int DATA_W = 16;
    localparam int B = 10;
    localparam int PER_W = 16;
    localparam int GAP = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic              ctl_en = 0, ctl_evt = 0;
    logic [BSN_W-1:0]  ctl_start_bsn = '0;
    logic [PER_W-1:0]  ctl_period = 16'd45;
    logic              in_sop = 0, in_eop = 0, in_valid = 0, in_sync = 0;
    logic [BSN_W-1:0]  in_bsn = '0;
    logic [DATA_W-1:0] in_data = '0;
    logic              out_sop, out_eop, out_valid, out_sync, out_start, out_enable;
    logic [BSN_W-1:0]  out_bsn, mon_cur_bsn, mon_in_sync_bsn, mon_out_sync_bsn;
    logic [DATA_W-1:0] out_data;

    bsn_sync_regen #(.BSN_W(BSN_W), .DATA_W(DATA_W), .BLK_SIZE(B), .PER_W(PER_W)) dut_i (
        .clk(clk), .rst(rst), .ctl_en(ctl_en), .ctl_evt(ctl_evt),
        .ctl_start_bsn(ctl_start_bsn), .ctl_period(ctl_period),
        .in_sop(in_sop), .in_eop(in_eop), .in_valid(in_valid), .in_sync(in_sync),
        .in_bsn(in_bsn), .in_data(in_data),
        .out_sop(out_sop), .out_eop(out_eop), .out_valid(out_valid), .out_sync(out_sync),
        .out_bsn(out_bsn), .out_data(out_data), .out_start(out_start), .out_enable(out_enable),
        .mon_cur_bsn(mon_cur_bsn), .mon_in_sync_bsn(mon_in_sync_bsn),
        .mon_out_sync_bsn(mon_out_sync_bsn)
    );

    int n_chk = 0, n_err = 0, pass_err = 0;
    int cyc = 0, eop_cyc = -1, fall_cyc = -1;
    bit prev_en = 0, done = 0;
    int rec_n = 0;
    longint rec_bsn [64];
    bit rec_sync [64];
    bit rec_start [64];

    logic p_sop, p_eop, p_valid;
    logic [BSN_W-1:0] p_bsn;
    logic [DATA_W-1:0] p_data;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // one clock: remember what is applied, sample one cycle later at negedge
    task automatic step();
        p_sop = in_sop; p_eop = in_eop; p_valid = in_valid;
        p_bsn = in_bsn; p_data = in_data;
        @(negedge clk);
        cyc++;
        if (out_enable) begin
            if (out_bsn !== p_bsn || out_data !== p_data || out_valid !== p_valid ||
                out_sop !== p_sop || out_eop !== p_eop) pass_err++;
            if (out_sop && rec_n < 64) begin
                rec_bsn[rec_n] = longint'(out_bsn);
                rec_sync[rec_n] = out_sync;
                rec_start[rec_n] = out_start;
                rec_n++;
            end
        end
        if (out_eop) eop_cyc = cyc;
        if (prev_en && !out_enable) fall_cyc = cyc;
        prev_en = out_enable;
    endtask

    task automatic blk(input longint bsn, input bit isync, input int drop_at);
        for (int i = 0; i < B; i++) begin
            if (i == drop_at) ctl_en = 1'b0;
            in_sop = (i == 0); in_eop = (i == B - 1); in_valid = 1'b1;
            in_sync = isync && (i == 0);
            in_bsn = BSN_W'(bsn);
            in_data = {8'(bsn), 8'(i)};
            step();
        end
        in_sop = 0; in_eop = 0; in_valid = 0; in_sync = 0;
        repeat (GAP) step();
    endtask

    task automatic blks(input longint first, input longint last);
        for (longint b = first; b <= last; b++) blk(b, (b % 9) == 0, -1);
    endtask

    task automatic ctl(input bit lvl, input longint st, input int per);
        ctl_en = lvl; ctl_evt = 1'b1; ctl_start_bsn = BSN_W'(st);
        ctl_period = PER_W'(per);
        step();
        ctl_evt = 1'b0;
    endtask

    // block k since kp carries sync if a multiple of per lies in its sample range
    function automatic bit exp_sync(input longint kp, input longint k, input longint per);
        longint lo, hi, first;
        lo = (kp + 1) * B;
        hi = (k + 1) * B - 1;
        first = ((lo + per - 1) / per) * per;
        return first <= hi;
    endfunction

    task automatic verify_recs(input longint ref_a, input longint per_a, input longint sw,
                               input longint ref_b, input longint per_b,
                               input longint first_prev, input string tag,
                               output longint last_sync);
        longint prev;
        bit prev_b;
        prev = first_prev; prev_b = 0; last_sync = -1;
        for (int i = 0; i < rec_n; i++) begin
            longint b, rf, pr, kp;
            bit inb, seg_start, es;
            b = rec_bsn[i];
            inb = (b >= sw);
            rf = inb ? ref_b : ref_a;
            pr = inb ? per_b : per_a;
            seg_start = (i == 0) ? (first_prev < 0) : (inb != prev_b);
            kp = seg_start ? -1 : prev - rf;
            es = exp_sync(kp, b - rf, pr);
            chk(rec_sync[i] == es, tag, $sformatf("sync at bsn %0d", b), rec_sync[i], es);
            chk(rec_start[i] == seg_start, "R5", $sformatf("start at bsn %0d", b),
                rec_start[i], seg_start);
            if (es) last_sync = b;
            prev = b; prev_b = inb;
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (4) step();
        rst = 1'b0;
        step();
        chk(!out_enable && !out_valid && !out_sop && !out_start && !out_sync, "R10",
            "outputs quiet after reset", out_enable, 0);
        chk(mon_cur_bsn == 0 && mon_in_sync_bsn == 0 && mon_out_sync_bsn == 0, "R10",
            "status cleared", mon_cur_bsn, 0);
    endtask

    task automatic t_prelude();
        blk(100, 1, -1); blk(101, 0, -1); blk(102, 0, -1);
        chk(mon_cur_bsn == 102, "R9", "current bsn", mon_cur_bsn, 102);
        chk(mon_in_sync_bsn == 100, "R9", "input sync bsn", mon_in_sync_bsn, 100);
        chk(rec_n == 0, "R10", "no output before enable", rec_n, 0);
    endtask

    task automatic t_enable();
        longint ls;
        rec_n = 0; pass_err = 0;
        ctl(1, 106, 45);
        blks(103, 120);
        chk(rec_n == 15, "R2", "forwarded block count", rec_n, 15);
        chk(rec_bsn[0] == 106, "R2", "first forwarded bsn", rec_bsn[0], 106);
        verify_recs(106, 45, 64'h7fffffff, 0, 45, -1, "R6", ls);
        chk(pass_err == 0, "R1", "pass-through mismatches", pass_err, 0);
        chk(mon_out_sync_bsn == ls, "R9", "output sync bsn", mon_out_sync_bsn, ls);
        chk(mon_in_sync_bsn == 117, "R9", "input sync bsn", mon_in_sync_bsn, 117);
    endtask

    task automatic t_stop();
        rec_n = 0;
        blk(121, 0, 4);
        blk(122, 0, -1); blk(123, 0, -1);
        chk(rec_n == 1 && rec_bsn[0] == 121, "R4", "last block completed", rec_n, 1);
        chk(fall_cyc == eop_cyc + 1, "R4", "enable fall cycle", fall_cyc, eop_cyc + 1);
        chk(!out_enable, "R4", "disabled after stop", out_enable, 0);
    endtask

    task automatic t_past();
        rec_n = 0;
        ctl(1, 120, 45);
        blks(124, 127);
        chk(rec_n == 0, "R3", "blocks forwarded with past start", rec_n, 0);
        chk(!out_enable, "R3", "enable with past start", out_enable, 0);
    endtask

    task automatic t_reenable();
        longint ls;
        rec_n = 0; pass_err = 0;
        ctl(1, 130, 20);
        blks(128, 140);
        ctl(1, 150, 45);
        blks(141, 160);
        chk(rec_n == 31, "R7", "forwarded block count", rec_n, 31);
        verify_recs(130, 20, 150, 150, 45, -1, "R7", ls);
        chk(pass_err == 0, "R1", "pass-through mismatches", pass_err, 0);
    endtask

    task automatic t_lost();
        longint ls;
        rec_n = 0; pass_err = 0;
        blk(161, 0, -1); blk(162, 0, -1);
        blks(170, 175);
        chk(rec_n == 8, "R8", "forwarded block count", rec_n, 8);
        verify_recs(150, 45, 64'h7fffffff, 0, 45, 160, "R8", ls);
        chk(mon_out_sync_bsn == ls, "R9", "output sync bsn after loss", mon_out_sync_bsn, ls);
        chk(pass_err == 0, "R1", "pass-through mismatches", pass_err, 0);
        ctl_en = 0;
        repeat (4) step();
        chk(!out_enable, "R10", "disabled at end", out_enable, 0);
    endtask

    initial begin
        t_reset();
        t_prelude();
        t_enable();
        t_stop();
        t_past();
        t_reenable();
        t_lost();
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL R10 watchdog: actual %0d expected %0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule